// File: doc/BRIEF.md
# Radix-4 SRT Iterative Divider

This block divides one unsigned W-bit integer by another and returns the quotient and the remainder. It produces two quotient bits per clock. Each step picks a signed digit in {-2, -1, 0, +1, +2}. A small combinational rule picks the digit from a short estimate of the partial remainder and from the three divisor bits that follow its leading one. The selection uses no stored table. The divisor is first shifted left until its top bit is set. The dividend is shifted by the same amount. At the end the remainder is shifted back.

Each step forms a multiple of the divisor: once or twice, with a sign. The block adds that multiple to the partial remainder. A mux after the adder keeps the unchanged remainder when the digit is zero. The chosen value is then multiplied by four. Positive and negative digit magnitudes go into two separate registers. One subtraction at the end turns them into the binary quotient. If the remainder ends negative, the block adds the divisor back once and lowers the quotient by one. A caller waits for `ready`, pulses `start` with both operands, and collects the result when `valid` pulses.

Top module: `srt4_divider`

## Requirements
- R1: After reset, `ready` is 1, and `valid`, `quotient`, `remainder` and `div_by_zero` are all 0.
- R2: `ready` is high only when the block is idle. A `start` seen while `ready` is high captures both operands. `ready` is low in the following cycle and stays low until the result appears. `valid` is high for exactly one cycle per accepted operation.
- R3: For a nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend minus quotient times divisor, so `remainder` is less than `divisor`.
- R4: For a nonzero divisor, `valid` is high in the cycle that begins W/2+2 rising edges after the edge that accepted `start`. That is 10 edges for W = 16.
- R5: In every iteration the digit comes from the sign bit, two integer bits and three fraction bits of the partial remainder and from the three divisor bits after its leading one. The partial remainder then stays within 8/3 of the normalized divisor.
- R6: The result is exact for every leading-zero count of the divisor. This includes a divisor of 1, a divisor with its top bit set, a zero dividend, and a dividend smaller than, equal to, or at the maximum compared with the divisor.
- R7: A zero divisor gives `div_by_zero` = 1, an all-ones `quotient`, and a `remainder` equal to the dividend. `valid` is high one rising edge after the accepting edge. The next division with a nonzero divisor clears `div_by_zero`.
- R8: A `start` while the block is busy is ignored: it neither changes the running result nor produces another `valid`. `quotient`, `remainder` and `div_by_zero` hold their values between results, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while `ready` is high |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| ready | output | 1 | Block idle and able to take `start` |
| valid | output | 1 | One-cycle pulse: result outputs are fresh |
| quotient | output | W | Unsigned quotient (all ones on a zero divisor) |
| remainder | output | W | Unsigned remainder (the dividend on a zero divisor) |
| div_by_zero | output | 1 | The last operation had a zero divisor |

## Verification
Some properties are checked on every cycle. The partial remainder must stay inside its 8/3 bound at every iteration, which is the real test of the digit-selection thresholds. Each nonzero result must satisfy quotient times divisor plus remainder equals the dividend, with the remainder below the divisor. The handshake rules must hold: `valid` is a single pulse, `ready` drops after an accepted start, and the outputs hold steady between pulses. Only the bench scenarios can show the exact latency count, the zero-divisor values, that a busy-time `start` is ignored, and that results are right across many divisor normalizations.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

   // Signed quotient digit: sign, nonzero, magnitude two (don't-care when zero)
   typedef struct packed {
      logic neg;
      logic nz;
      logic two;
   } srt_digit_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } srt_state_t;

endpackage

// File: rtl/srt4_lzc.sv
module srt4_lzc #(
   parameter int W  = 16,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   output logic [SW-1:0] cnt
);

   generate
      if (W < 2) begin : g_bad_width
         $error("srt4_lzc: W must be at least 2");
      end
   endgenerate

   // Highest set bit wins; a zero input reports zero.
   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         if (val[i]) cnt = SW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/srt4_digit_sel.sv
module srt4_digit_sel
   import srt4_pkg::*;
(
   input  logic [5:0]  est,   // sign, 2 integer bits, 3 fraction bits
   input  logic [2:0]  dtop,  // divisor bits after the leading one
   output srt_digit_t  dig
);

   logic [4:0] mag;
   logic [4:0] t_one;
   logic [4:0] t_two;

   always_comb begin
      // Ones-complement fold: a negative estimate maps onto the same
      // comparisons as a positive one, because both thresholds sit on the grid.
      mag   = est[4:0] ^ {5{est[5]}};
      t_one = dtop[2] ? 5'd3 : 5'd2;
      case (dtop)
         3'd0:    t_two = 5'd6;
         3'd1:    t_two = 5'd7;
         3'd2:    t_two = 5'd8;
         3'd3:    t_two = 5'd8;
         3'd4:    t_two = 5'd9;
         3'd5:    t_two = 5'd10;
         3'd6:    t_two = 5'd10;
         default: t_two = 5'd11;
      endcase
      dig.neg = est[5];
      dig.nz  = (mag >= t_one);
      dig.two = (mag >= t_two);
   end

endmodule

// File: rtl/srt4_step.sv
module srt4_step
   import srt4_pkg::*;
#(
   parameter int PW = 35
) (
   input  logic [PW-1:0] p_cur,
   input  logic [PW-1:0] dvs,
   input  srt_digit_t    dig,
   output logic [PW-1:0] p_nxt
);

   logic [PW-1:0] mult;
   logic [PW-1:0] addend;
   logic [PW-1:0] sum;
   logic [PW-1:0] keep;

   always_comb begin
      mult   = dig.two ? (dvs << 1) : dvs;
      // remainder minus digit*divisor: a positive digit subtracts
      addend = dig.neg ? mult : (~mult + 1'b1);
      sum    = p_cur + addend;
      // zero digit bypasses the adder, so a wrong 'two' there is harmless
      keep   = dig.nz ? sum : p_cur;
      p_nxt  = keep << 2;
   end

endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
   import srt4_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         ready,
   output logic         valid,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder,
   output logic         div_by_zero
);

   localparam int NI = W / 2 + 1;       // digits, one extra for headroom
   localparam int PW = 2 * W + 3;       // signed partial remainder width
   localparam int SW = $clog2(W);
   localparam int CW = $clog2(NI + 1);

   generate
      if ((W % 2) != 0 || W < 4) begin : g_bad_width
         $error("srt4_divider: W must be even and at least 4");
      end
   endgenerate

   srt_state_t    state;
   logic [PW-1:0] p_q;
   logic [PW-1:0] dsc_q;
   logic [SW-1:0] sh_q;
   logic [W-1:0]  qp_q, qn_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  a_q, b_q;
   logic          zero_q;

   logic [SW-1:0] lz;
   logic [PW-1:0] p_load, d_load, p_nxt;
   srt_digit_t    dig;
   logic [1:0]    dmag;

   srt4_lzc #(.W(W), .SW(SW)) u_lzc (
      .val (divisor),
      .cnt (lz)
   );

   assign p_load = {{(PW-W){1'b0}}, dividend} << lz;
   assign d_load = ({{(PW-W){1'b0}}, divisor} << lz) << W;

   srt4_digit_sel u_sel (
      .est  (p_q[2*W+2 -: 6]),
      .dtop (dsc_q[2*W-2 -: 3]),
      .dig  (dig)
   );

   srt4_step #(.PW(PW)) u_step (
      .p_cur (p_q),
      .dvs   (dsc_q),
      .dig   (dig),
      .p_nxt (p_nxt)
   );

   assign dmag = dig.nz ? (dig.two ? 2'd2 : 2'd1) : 2'd0;

   // Final conversion and correction
   logic [PW-1:0] r_full, r_fix;
   logic [W-1:0]  q_fin, r_fin;

   always_comb begin
      r_full = $signed(p_q) >>> (W + 2);
      if (r_full[PW-1]) begin
         r_fix = r_full + (dsc_q >> W);
         q_fin = qp_q - qn_q - 1'b1;
      end else begin
         r_fix = r_full;
         q_fin = qp_q - qn_q;
      end
      r_fin = W'(r_fix >> sh_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         p_q         <= '0;
         dsc_q       <= '0;
         sh_q        <= '0;
         qp_q        <= '0;
         qn_q        <= '0;
         cnt_q       <= '0;
         a_q         <= '0;
         b_q         <= '0;
         zero_q      <= 1'b0;
         valid       <= 1'b0;
         quotient    <= '0;
         remainder   <= '0;
         div_by_zero <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  a_q    <= dividend;
                  b_q    <= divisor;
                  sh_q   <= lz;
                  p_q    <= p_load;
                  dsc_q  <= d_load;
                  qp_q   <= '0;
                  qn_q   <= '0;
                  cnt_q  <= CW'(NI);
                  zero_q <= (divisor == '0);
                  state  <= (divisor == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               p_q   <= p_nxt;
               qp_q  <= {qp_q[W-3:0], dig.neg ? 2'd0 : dmag};
               qn_q  <= {qn_q[W-3:0], dig.neg ? dmag : 2'd0};
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) state <= ST_FIN;
            end
            ST_FIN: begin
               valid <= 1'b1;
               state <= ST_IDLE;
               if (zero_q) begin
                  quotient    <= '1;
                  remainder   <= a_q;
                  div_by_zero <= 1'b1;
               end else begin
                  quotient    <= q_fin;
                  remainder   <= r_fin;
                  div_by_zero <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ready = (state == ST_IDLE);

   // ---------------- assertions ----------------
   logic [PW-1:0]  p_abs;
   logic [PW+2:0]  bound_lhs, bound_rhs;
   logic [2*W:0]   recon;

   assign p_abs     = p_q[PW-1] ? (~p_q + 1'b1) : p_q;
   assign bound_lhs = {3'b000, p_abs} + {2'b00, p_abs, 1'b0};
   assign bound_rhs = {dsc_q, 3'b000};
   assign recon     = ({{(W+1){1'b0}}, quotient} * {{(W+1){1'b0}}, b_q})
                      + {{(W+1){1'b0}}, remainder};

   // R5
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (bound_lhs <= bound_rhs));

   // R3
   exact_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !div_by_zero) |-> (recon == {{(W+1){1'b0}}, a_q} && remainder < b_q));

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R2
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);

   // R8
   outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

// File: tb/srt4_divider_test.sv
module srt4_divider_test;

   localparam int W     = 16;
   localparam int CLK_P = 10;
   localparam int LAT   = W / 2 + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         ready, valid, div_by_zero;
   logic [W-1:0] quotient, remainder;

   int checks = 0;
   int errs   = 0;

   srt4_divider #(.W(W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .dividend    (dividend),
      .divisor     (divisor),
      .ready       (ready),
      .valid       (valid),
      .quotient    (quotient),
      .remainder   (remainder),
      .div_by_zero (div_by_zero)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Issue one operation and wait for its result at a negedge.
   task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] q, output logic [W-1:0] r,
                          output logic e, output int lat, output bit busy_ok);
      @(negedge clk);
      while (!ready) @(negedge clk);
      dividend = a;
      divisor  = b;
      start    = 1'b1;
      lat      = 0;
      busy_ok  = 1'b1;
      do begin
         @(negedge clk);
         lat++;
         start = 1'b0;
         if (!valid && ready) busy_ok = 1'b0;
      end while (!valid && lat < 200);
      q = quotient;
      r = remainder;
      e = div_by_zero;
   endtask

   task automatic check_div(input logic [W-1:0] a, input logic [W-1:0] b,
                            input string tag);
      logic [W-1:0] q, r;
      logic e;
      int lat;
      bit bz;
      run_div(a, b, q, r, e, lat, bz);
      chk(q == a / b, {tag, " quotient"}, 32'(q), 32'(a / b));
      chk(r == a % b, {tag, " remainder"}, 32'(r), 32'(a % b));
      chk(e == 1'b0, {tag, " div_by_zero"}, 32'(e), 32'd0);
   endtask

   task automatic t_reset_state;
      // R1
      chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 32'd1);
      chk(valid == 1'b0, "R1 valid after reset", 32'(valid), 32'd0);
      chk(quotient == '0, "R1 quotient after reset", 32'(quotient), 32'd0);
      chk(remainder == '0, "R1 remainder after reset", 32'(remainder), 32'd0);
      chk(div_by_zero == 1'b0, "R1 div_by_zero after reset", 32'(div_by_zero), 32'd0);
   endtask

   task automatic t_corners;
      // R6 normalization corners, R3 exact result
      check_div(16'd100, 16'd7, "R3 small");
      check_div(16'hFFFF, 16'd1, "R6 divisor one");
      check_div(16'hFFFF, 16'h8000, "R6 divisor msb set");
      check_div(16'hFFFF, 16'hFFFF, "R6 equal max");
      check_div(16'h0000, 16'h1234, "R6 zero dividend");
      check_div(16'h0005, 16'h0006, "R6 dividend below divisor");
      check_div(16'h4321, 16'h4321, "R6 equal");
      check_div(16'hFFFF, 16'd3, "R6 divisor three");
      check_div(16'hFFFE, 16'h7FFF, "R6 near half");
      check_div(16'h8000, 16'h0002, "R6 power of two");
      check_div(16'hABCD, 16'h0009, "R3 mixed");
      check_div(16'hFFFF, 16'h0181, "R3 mid divisor");
      for (int k = 0; k < W; k++) begin
         check_div(16'hFFFF, 16'(1) << k, "R6 each shift");
         check_div(16'hFFFF, (16'(1) << k) | 16'(k % 2), "R6 shift plus one");
      end
   endtask

   task automatic t_sweep;
      // R3 and R6 over many operand patterns
      logic [31:0] s;
      logic [W-1:0] a, b;
      s = 32'h1F2E3D4C;
      for (int n = 0; n < 400; n++) begin
         s = s ^ (s << 13);
         s = s ^ (s >> 17);
         s = s ^ (s << 5);
         a = s[15:0];
         b = s[31:16] >> s[3:0];
         if (b == '0) b = 16'd1;
         check_div(a, b, "R3 sweep");
      end
   endtask

   task automatic t_latency;
      // R4 and R2
      logic [W-1:0] q, r;
      logic e;
      int lat;
      bit bz;
      run_div(16'h9999, 16'h0013, q, r, e, lat, bz);
      chk(lat - 1 == LAT, "R4 latency edges", 32'(lat - 1), 32'(LAT));
      chk(bz, "R2 ready low while busy", 32'(bz), 32'd1);
      chk(ready == 1'b1, "R2 ready with result", 32'(ready), 32'd1);
      @(negedge clk);
      chk(valid == 1'b0, "R2 valid one cycle", 32'(valid), 32'd0);
   endtask

   task automatic t_zero;
      // R7
      logic [W-1:0] q, r;
      logic e;
      int lat;
      bit bz;
      run_div(16'h5A5A, 16'h0000, q, r, e, lat, bz);
      chk(e == 1'b1, "R7 flag set", 32'(e), 32'd1);
      chk(q == 16'hFFFF, "R7 quotient ones", 32'(q), 32'hFFFF);
      chk(r == 16'h5A5A, "R7 remainder is dividend", 32'(r), 32'h5A5A);
      chk(lat - 1 == 1, "R7 latency edges", 32'(lat - 1), 32'd1);
      run_div(16'd50, 16'd5, q, r, e, lat, bz);
      chk(e == 1'b0, "R7 flag cleared", 32'(e), 32'd0);
      chk(q == 16'd10, "R7 next quotient", 32'(q), 32'd10);
   endtask

   task automatic t_busy;
      // R8: start during a running operation is ignored
      int seen;
      @(negedge clk);
      while (!ready) @(negedge clk);
      dividend = 16'd1000;
      divisor  = 16'd33;
      start    = 1'b1;
      @(negedge clk);
      dividend = 16'd7;
      divisor  = 16'd0;
      repeat (3) @(negedge clk);
      start = 1'b0;
      seen = 0;
      while (!valid && seen < 200) begin
         @(negedge clk);
         seen++;
      end
      chk(quotient == 16'd30, "R8 busy start quotient", 32'(quotient), 32'd30);
      chk(remainder == 16'd10, "R8 busy start remainder", 32'(remainder), 32'd10);
      chk(div_by_zero == 1'b0, "R8 busy start flag", 32'(div_by_zero), 32'd0);
      seen = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (valid) seen++;
      end
      chk(seen == 0, "R8 no extra valid", 32'(seen), 32'd0);
   endtask

   task automatic t_hold;
      // R8: outputs hold while inputs wander with no start
      logic [W-1:0] q0, r0;
      q0 = quotient;
      r0 = remainder;
      for (int c = 0; c < 6; c++) begin
         dividend = 16'(c * 4099);
         divisor  = 16'(c);
         @(negedge clk);
      end
      chk(quotient == q0, "R8 quotient held", 32'(quotient), 32'(q0));
      chk(remainder == r0, "R8 remainder held", 32'(remainder), 32'(r0));
      chk(valid == 1'b0, "R8 no valid without start", 32'(valid), 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_corners();
      t_latency();
      t_zero();
      t_busy();
      t_hold();
      t_sweep();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule